// File: doc/BRIEF.md
# Input Shift Accumulator with Automatic Push

This block gathers input bits into a 32-bit accumulation register on behalf of a small command sequencer. Each shift command supplies a source word and a 5-bit count. The register moves left or right by that count, as a static direction setting selects. The lowest bits of the source word then fill the end that was opened. A saturating counter records how many bits have been collected since the last clear.

When automatic push is enabled, a shift that brings the counter to the programmed threshold does three things in the same cycle. It presents the freshly shifted word on the receive-FIFO write port, then clears both the register and the counter. Two explicit push commands exist. One pushes unconditionally. The other pushes only once the threshold has been reached. Each can block on a full FIFO or not block. If the FIFO is full and a push would have to wait, the block lowers its ready output. Nothing is applied until the sequencer retries with room in the FIFO.

Top module: `isr_accum`

## Requirements
- R1: While reset is asserted, and after it is released, the register reads 0, the counter reads 0, no FIFO write is requested, and ready is high.
- R2: A count field of 00000 means 32 bits and any other value means that many bits. Each accepted shift adds the count to the counter, which saturates at 32.
- R3: With the direction bit at 0 (left), a shift gives register = (register << n) | (source & low-n-bit mask). Source bits above bit n-1 are ignored.
- R4: With the direction bit at 1 (right), a shift gives register = (register >> n) | ((source & low-n-bit mask) << (32 - n)). The inserted bits keep their order, so eight 1-bit right shifts and a further 24-bit zero shift leave the first byte in bits 7..0.
- R5: With autopush on, a shift whose new count is >= the threshold (threshold field 0 means 32) writes the shifted word to the FIFO port in that same cycle. After that cycle the register and the counter read 0. With autopush off, no write occurs.
- R6: When an autopush is due and the FIFO is full, ready is low, no write occurs, and the register and counter are unchanged. The same command completes once the full flag drops.
- R7: Opcode 01 (push) writes the whole register to the FIFO and clears the register and the counter. With the block bit set and the FIFO full, it stalls as in R6. With the block bit clear and the FIFO full, the word is dropped (no write) but the clear still happens.
- R8: Opcode 10 (push if threshold reached) acts like R7 when the counter is >= the threshold. Otherwise it is accepted with no write and no change of state.
- R9: Opcode 11 and cycles with command-valid low change nothing and request no write. Opcode 00 is a shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_dir_right_i | input | 1 | Shift direction: 1 right, 0 left |
| cfg_autopush_i | input | 1 | Enables automatic push on threshold |
| cfg_thresh_i | input | 5 | Push threshold, 0 means 32 |
| cmd_valid_i | input | 1 | A command is presented |
| cmd_op_i | input | 2 | 00 shift, 01 push, 10 push if threshold reached, 11 no-op |
| cmd_block_i | input | 1 | Explicit push waits on a full FIFO when set |
| cmd_count_i | input | 5 | Bits to shift, 0 means 32 |
| cmd_data_i | input | 32 | Source word for a shift |
| cmd_ready_o | output | 1 | Low while the presented command is stalled |
| fifo_full_i | input | 1 | Receive FIFO cannot accept a word |
| fifo_push_o | output | 1 | Write strobe toward the receive FIFO |
| fifo_data_o | output | 32 | Word written to the receive FIFO |
| isr_o | output | 32 | Current register contents |
| count_o | output | 6 | Current bit counter (0 to 32) |

## Verification
Shifts are run with small counts, with the 32-bit code and with 31 bits, in both directions. The sources carry ones above the count, which shows that only the low source bits enter and that left and right placement differ. Thresholds are tried when the count lands exactly on them, when it overshoots them, and at the 32 encoding, so that the >= comparison and the zero code are both covered. Every push variant is run against an empty and a full FIFO, once blocking and once not. This separates a stall, a dropped word and a real write. Mid-run reset and idle cycles confirm that the state clears or holds.

// File: rtl/isr_acc_pkg.sv
package isr_acc_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    OP_SHIFT   = 2'b00,
    OP_PUSH    = 2'b01,
    OP_PUSH_TH = 2'b10,
    OP_NOP     = 2'b11
  } isr_op_e;
endpackage

// File: rtl/isr_rst_sync.sv
module isr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/isr_shift_unit.sv
module isr_shift_unit #(
  parameter int unsigned DATA_W = isr_acc_pkg::WORD_W,
  localparam int unsigned FLD_W = $clog2(DATA_W),
  localparam int unsigned CNT_W = FLD_W + 1
) (
  input  logic [DATA_W-1:0] isr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [FLD_W-1:0]  field_i,
  input  logic              dir_right_i,
  output logic [DATA_W-1:0] isr_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [CNT_W-1:0]  amt;
  logic [DATA_W-1:0] keep_mask;
  logic [DATA_W-1:0] src_low;
  logic [CNT_W:0]    sum;

  // a zero field encodes the full word width
  always_comb begin
    if (field_i == '0) amt = CNT_W'(DATA_W);
    else               amt = {1'b0, field_i};
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign keep_mask[i] = (CNT_W'(i) < amt);
  end

  assign src_low = src_i & keep_mask;

  always_comb begin
    if (dir_right_i) isr_o = (isr_i >> amt) | (src_low << (CNT_W'(DATA_W) - amt));
    else             isr_o = (isr_i << amt) | src_low;
  end

  always_comb begin
    sum = {1'b0, cnt_i} + {1'b0, amt};
    if (sum > (CNT_W + 1)'(DATA_W)) cnt_o = CNT_W'(DATA_W);
    else                            cnt_o = sum[CNT_W-1:0];
  end
endmodule

// File: rtl/isr_push_ctrl.sv
module isr_push_ctrl
  import isr_acc_pkg::*;
#(
  parameter int unsigned DATA_W = isr_acc_pkg::WORD_W,
  localparam int unsigned FLD_W = $clog2(DATA_W),
  localparam int unsigned CNT_W = FLD_W + 1
) (
  input  logic             en_i,
  input  logic             valid_i,
  input  logic [1:0]       op_i,
  input  logic             block_i,
  input  logic             full_i,
  input  logic             autopush_i,
  input  logic [FLD_W-1:0] thresh_i,
  input  logic [CNT_W-1:0] cnt_cur_i,
  input  logic [CNT_W-1:0] cnt_new_i,
  output logic             ready_o,
  output logic             push_o,
  output logic             clear_o,
  output logic             shift_en_o,
  output logic             sel_shift_o
);
  logic [CNT_W-1:0] thr_eff;
  logic             reach_cur, reach_new;
  logic             want_push, stall, is_shift, fire;
  isr_op_e          op;

  assign op = isr_op_e'(op_i);

  always_comb begin
    if (thresh_i == '0) thr_eff = CNT_W'(DATA_W);
    else                thr_eff = {1'b0, thresh_i};
  end

  assign reach_cur = (cnt_cur_i >= thr_eff);
  assign reach_new = (cnt_new_i >= thr_eff);

  always_comb begin
    want_push = 1'b0;
    stall     = 1'b0;
    is_shift  = 1'b0;
    unique case (op)
      OP_SHIFT: begin
        is_shift  = 1'b1;
        want_push = autopush_i & reach_new;
        stall     = want_push & full_i;
      end
      OP_PUSH: begin
        want_push = 1'b1;
        stall     = block_i & full_i;
      end
      OP_PUSH_TH: begin
        want_push = reach_cur;
        stall     = reach_cur & block_i & full_i;
      end
      default: begin
        want_push = 1'b0;
      end
    endcase
  end

  assign ready_o     = ~(valid_i & stall);
  assign fire        = valid_i & en_i & ~stall;
  assign push_o      = fire & want_push & ~full_i;
  assign clear_o     = fire & want_push;
  assign shift_en_o  = fire & is_shift;
  assign sel_shift_o = is_shift;
endmodule

// File: rtl/isr_accum.sv
module isr_accum #(
  parameter int unsigned DATA_W = isr_acc_pkg::WORD_W,
  localparam int unsigned FLD_W = $clog2(DATA_W),
  localparam int unsigned CNT_W = FLD_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_dir_right_i,
  input  logic              cfg_autopush_i,
  input  logic [FLD_W-1:0]  cfg_thresh_i,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic              cmd_block_i,
  input  logic [FLD_W-1:0]  cmd_count_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  output logic              cmd_ready_o,
  input  logic              fifo_full_i,
  output logic              fifo_push_o,
  output logic [DATA_W-1:0] fifo_data_o,
  output logic [DATA_W-1:0] isr_o,
  output logic [CNT_W-1:0]  count_o
);
  logic              rst_n_sync;
  logic [DATA_W-1:0] isr_q, isr_d, isr_shifted;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_shifted;
  logic              clear, shift_en, sel_shift, upd_en;

  isr_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  isr_shift_unit #(.DATA_W(DATA_W)) u_shift (
    .isr_i       (isr_q),
    .cnt_i       (cnt_q),
    .src_i       (cmd_data_i),
    .field_i     (cmd_count_i),
    .dir_right_i (cfg_dir_right_i),
    .isr_o       (isr_shifted),
    .cnt_o       (cnt_shifted)
  );

  isr_push_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .en_i        (rst_n_sync),
    .valid_i     (cmd_valid_i),
    .op_i        (cmd_op_i),
    .block_i     (cmd_block_i),
    .full_i      (fifo_full_i),
    .autopush_i  (cfg_autopush_i),
    .thresh_i    (cfg_thresh_i),
    .cnt_cur_i   (cnt_q),
    .cnt_new_i   (cnt_shifted),
    .ready_o     (cmd_ready_o),
    .push_o      (fifo_push_o),
    .clear_o     (clear),
    .shift_en_o  (shift_en),
    .sel_shift_o (sel_shift)
  );

  // next-state selection
  always_comb begin
    isr_d = isr_q;
    cnt_d = cnt_q;
    if (clear) begin
      isr_d = '0;
      cnt_d = '0;
    end else if (shift_en) begin
      isr_d = isr_shifted;
      cnt_d = cnt_shifted;
    end
  end

  assign upd_en = clear | shift_en;

  always_ff @(posedge clk_i or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      isr_q <= '0;
      cnt_q <= '0;
    end else if (upd_en) begin
      isr_q <= isr_d;
      cnt_q <= cnt_d;
    end
  end

  assign fifo_data_o = sel_shift ? isr_shifted : isr_q;
  assign isr_o       = isr_q;
  assign count_o     = cnt_q;
endmodule

// File: rtl/isr_acc_chk.sv
module isr_acc_chk #(
  parameter int unsigned DATA_W = isr_acc_pkg::WORD_W,
  localparam int unsigned CNT_W = $clog2(DATA_W) + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic              cmd_ready_o,
  input logic              fifo_full_i,
  input logic              fifo_push_o,
  input logic [DATA_W-1:0] isr_o,
  input logic [CNT_W-1:0]  count_o
);
  AST_CNT_SATURATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DATA_W)); // R2

  AST_PUSH_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_push_o |=> (isr_o == '0) && (count_o == '0)); // R5

  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_push_o |-> !fifo_full_i); // R6

  AST_STALL_NEEDS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_ready_o |-> (fifo_full_i && cmd_valid_i)); // R6

  AST_STALL_HOLDS_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_ready_o |=> ($stable(isr_o) && $stable(count_o))); // R6

  AST_WRITE_NEEDS_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_push_o |-> (cmd_valid_i && cmd_ready_o)); // R9

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> ($stable(isr_o) && $stable(count_o))); // R9
endmodule

bind isr_accum isr_acc_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_n_sync),
  .cmd_valid_i (cmd_valid_i),
  .cmd_ready_o (cmd_ready_o),
  .fifo_full_i (fifo_full_i),
  .fifo_push_o (fifo_push_o),
  .isr_o       (isr_o),
  .count_o     (count_o)
);

// File: tb/isr_accum_tb_top.sv
module isr_accum_tb_top;
  logic        clk, rst_n;
  logic        dir_r, apush, cvalid, cblock, full;
  logic [4:0]  thr, ccnt;
  logic [1:0]  cop;
  logic [31:0] cdata;
  logic        rdy, push;
  logic [31:0] pdata, isr;
  logic [5:0]  cnt;

  int checks = 0;
  int fails  = 0;

  isr_accum dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_dir_right_i(dir_r), .cfg_autopush_i(apush), .cfg_thresh_i(thr),
    .cmd_valid_i(cvalid), .cmd_op_i(cop), .cmd_block_i(cblock),
    .cmd_count_i(ccnt), .cmd_data_i(cdata), .cmd_ready_o(rdy),
    .fifo_full_i(full), .fifo_push_o(push), .fifo_data_o(pdata),
    .isr_o(isr), .count_o(cnt)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic        dir;
    logic        ap;
    logic [4:0]  th;
    logic [1:0]  op;
    logic        blk;
    logic [4:0]  n;
    logic [31:0] d;
    logic        fl;
    logic        e_rdy;
    logic        e_push;
    logic [31:0] e_pd;
    logic [31:0] e_isr;
    logic [5:0]  e_cnt;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,5'd0, 2'b00,1'b0,5'd4, 32'hFFFF_FFF5,1'b0, 1'b1,1'b0,32'h0,        32'h0000_0005, 6'd4,  8'd3},
    '{1'b0,1'b0,5'd0, 2'b00,1'b0,5'd8, 32'h0000_00A3,1'b0, 1'b1,1'b0,32'h0,        32'h0000_05A3, 6'd12, 8'd3},
    '{1'b0,1'b0,5'd0, 2'b00,1'b0,5'd0, 32'h1234_5678,1'b0, 1'b1,1'b0,32'h0,        32'h1234_5678, 6'd32, 8'd2},
    '{1'b0,1'b0,5'd0, 2'b11,1'b1,5'd3, 32'hDEAD_BEEF,1'b0, 1'b1,1'b0,32'h0,        32'h1234_5678, 6'd32, 8'd9},
    '{1'b0,1'b0,5'd0, 2'b01,1'b1,5'd0, 32'h0,        1'b0, 1'b1,1'b1,32'h1234_5678,32'h0,         6'd0,  8'd7},
    '{1'b1,1'b0,5'd0, 2'b00,1'b0,5'd1, 32'h0000_0001,1'b0, 1'b1,1'b0,32'h0,        32'h8000_0000, 6'd1,  8'd4},
    '{1'b1,1'b0,5'd0, 2'b00,1'b0,5'd1, 32'hFFFF_FFFE,1'b0, 1'b1,1'b0,32'h0,        32'h4000_0000, 6'd2,  8'd4},
    '{1'b1,1'b0,5'd0, 2'b00,1'b0,5'd6, 32'h0000_002D,1'b0, 1'b1,1'b0,32'h0,        32'hB500_0000, 6'd8,  8'd4},
    '{1'b1,1'b0,5'd0, 2'b00,1'b0,5'd24,32'h0,        1'b0, 1'b1,1'b0,32'h0,        32'h0000_00B5, 6'd32, 8'd4},
    '{1'b1,1'b0,5'd0, 2'b10,1'b0,5'd0, 32'h0,        1'b0, 1'b1,1'b1,32'h0000_00B5,32'h0,         6'd0,  8'd8},
    '{1'b1,1'b0,5'd0, 2'b10,1'b1,5'd0, 32'h0,        1'b1, 1'b1,1'b0,32'h0,        32'h0,         6'd0,  8'd8},
    '{1'b0,1'b1,5'd8, 2'b00,1'b0,5'd4, 32'h0000_0009,1'b0, 1'b1,1'b0,32'h0,        32'h0000_0009, 6'd4,  8'd5},
    '{1'b0,1'b1,5'd8, 2'b00,1'b0,5'd4, 32'h0000_0006,1'b1, 1'b0,1'b0,32'h0,        32'h0000_0009, 6'd4,  8'd6},
    '{1'b0,1'b1,5'd8, 2'b00,1'b0,5'd4, 32'h0000_0006,1'b0, 1'b1,1'b1,32'h0000_0096,32'h0,         6'd0,  8'd6},
    '{1'b0,1'b1,5'd8, 2'b00,1'b0,5'd12,32'hFFFF_FABC,1'b0, 1'b1,1'b1,32'h0000_0ABC,32'h0,         6'd0,  8'd5},
    '{1'b0,1'b0,5'd0, 2'b00,1'b0,5'd3, 32'h0000_0007,1'b0, 1'b1,1'b0,32'h0,        32'h0000_0007, 6'd3,  8'd3},
    '{1'b0,1'b0,5'd0, 2'b01,1'b1,5'd0, 32'h0,        1'b1, 1'b0,1'b0,32'h0,        32'h0000_0007, 6'd3,  8'd7},
    '{1'b0,1'b0,5'd0, 2'b01,1'b0,5'd0, 32'h0,        1'b1, 1'b1,1'b0,32'h0,        32'h0,         6'd0,  8'd7},
    '{1'b0,1'b1,5'd0, 2'b00,1'b0,5'd16,32'h0000_BEEF,1'b0, 1'b1,1'b0,32'h0,        32'h0000_BEEF, 6'd16, 8'd5},
    '{1'b0,1'b1,5'd0, 2'b00,1'b0,5'd16,32'h0000_CAFE,1'b0, 1'b1,1'b1,32'hBEEF_CAFE,32'h0,         6'd0,  8'd5},
    '{1'b1,1'b1,5'd0, 2'b00,1'b0,5'd0, 32'h0F0F_0F0F,1'b0, 1'b1,1'b1,32'h0F0F_0F0F,32'h0,         6'd0,  8'd4},
    '{1'b1,1'b0,5'd0, 2'b00,1'b0,5'd31,32'hFFFF_FFFF,1'b0, 1'b1,1'b0,32'h0,        32'hFFFF_FFFE, 6'd31, 8'd4},
    '{1'b1,1'b0,5'd31,2'b10,1'b1,5'd0, 32'h0,        1'b1, 1'b0,1'b0,32'h0,        32'hFFFF_FFFE, 6'd31, 8'd8},
    '{1'b1,1'b0,5'd31,2'b10,1'b1,5'd0, 32'h0,        1'b0, 1'b1,1'b1,32'hFFFF_FFFE,32'h0,         6'd0,  8'd8}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string rtag(input logic [7:0] r);
    case (r)
      8'd2: rtag = "R2"; 8'd3: rtag = "R3"; 8'd4: rtag = "R4"; 8'd5: rtag = "R5";
      8'd6: rtag = "R6"; 8'd7: rtag = "R7"; 8'd8: rtag = "R8"; default: rtag = "R9";
    endcase
  endfunction

  task automatic idle();
    cvalid = 1'b0; cop = 2'b11; cblock = 1'b0; ccnt = 5'd0; cdata = '0; full = 1'b0;
  endtask

  initial begin : watchdog
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    dir_r = 1'b0; apush = 1'b0; thr = 5'd0;
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "isr in reset", isr, 32'h0);
    chk("R1", "count in reset", {26'h0, cnt}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "isr after reset", isr, 32'h0);
    chk("R1", "count after reset", {26'h0, cnt}, 32'h0);
    chk("R1", "push after reset", {31'h0, push}, 32'h0);
    chk("R1", "ready after reset", {31'h0, rdy}, 32'h1);

    for (int k = 0; k < NV; k++) begin
      dir_r = VEC[k].dir; apush = VEC[k].ap; thr = VEC[k].th;
      cvalid = 1'b1; cop = VEC[k].op; cblock = VEC[k].blk;
      ccnt = VEC[k].n; cdata = VEC[k].d; full = VEC[k].fl;
      #5;
      chk(rtag(VEC[k].req), $sformatf("v%0d ready", k), {31'h0, rdy}, {31'h0, VEC[k].e_rdy});
      chk(rtag(VEC[k].req), $sformatf("v%0d push", k), {31'h0, push}, {31'h0, VEC[k].e_push});
      if (VEC[k].e_push)
        chk(rtag(VEC[k].req), $sformatf("v%0d push data", k), pdata, VEC[k].e_pd);
      @(negedge clk);
      chk(rtag(VEC[k].req), $sformatf("v%0d isr", k), isr, VEC[k].e_isr);
      chk(rtag(VEC[k].req), $sformatf("v%0d count", k), {26'h0, cnt}, {26'h0, VEC[k].e_cnt});
    end

    // R9: valid low with a shift opcode present changes nothing
    dir_r = 1'b0; apush = 1'b0; thr = 5'd0;
    cvalid = 1'b1; cop = 2'b00; ccnt = 5'd5; cdata = 32'h0000_0015; full = 1'b0;
    @(negedge clk);
    cvalid = 1'b0; cdata = 32'hFFFF_FFFF; ccnt = 5'd7;
    #5;
    chk("R9", "no push while idle", {31'h0, push}, 32'h0);
    repeat (2) @(negedge clk);
    chk("R9", "isr held while idle", isr, 32'h0000_0015);
    chk("R9", "count held while idle", {26'h0, cnt}, 32'd5);

    // R1: reset in mid-run clears gathered state
    rst_n = 1'b0;
    #2;
    chk("R1", "isr cleared by reset", isr, 32'h0);
    chk("R1", "count cleared by reset", {26'h0, cnt}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "isr after second reset", isr, 32'h0);
    idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule